// File: doc/BRIEF.md
# Unipolar Sine-Triangle Bridge Modulator

This block turns two constant-amplitude reference sines into gate-drive signals for the four switches of a single-phase full bridge. The two sines are 180 degrees apart. All sample data is 8-bit offset binary, so code 128 stands for zero. A depth code scales both references about midscale. Each scaled sine is then compared with one shared triangular carrier, and the result drives one bridge leg. Each leg has an upper and a lower drive, and the lower drive is the complement of the upper one.

Scaling removes the midscale offset from the sample and from the depth code and multiplies the two signed terms. It divides the product by 127, truncating toward zero, and then restores the offset. The division uses a reciprocal multiply followed by a one-step remainder correction. The result is clipped to 0..255. The carrier passes through a delay line as deep as the scaling pipeline, so each comparison uses a sine and a carrier sample that entered in the same cycle. All four drives stay low during reset and until the first valid sample reaches the output.

Top module: `spwm_bridge`

## Requirements
- R1: The scaled level is ya = trunc((y-128)*(d-128)/127) + 128, where y is the reference code and d is the depth code. Division truncates toward zero, so a negative quotient rounds toward zero and not toward minus infinity.
- R2: A scaled level above 255 is clipped to 255, and one below 0 is clipped to 0. For example, y=0 with d=0 gives 255, and y=255 with d=0 gives 0.
- R3: A leg's upper drive is 1 when its scaled level is greater than or equal to the carrier code, and 0 otherwise. Equality gives 1.
- R4: Once output is valid, a leg's lower drive is always the inverse of its upper drive.
- R5: With d=128, both scaled levels equal 128 whatever the reference codes are.
- R6: Leg A uses ref_a and leg B uses ref_b, and both compare against the same carrier sample.
- R7: While rst is high, and for 4 clock edges after it falls, all four drives are 0. This includes both lower drives.
- R8: An input sampled at clock edge t affects the drives right after edge t+4. Reference, depth and carrier all have this same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 8 | Reference sine sample for leg A, offset binary |
| ref_b | input | 8 | Reference sine sample for leg B (180 degrees shifted), offset binary |
| carrier | input | 8 | Triangular carrier sample |
| depth | input | 8 | Modulation depth code; 128 gives zero amplitude |
| a_hi | output | 1 | Leg A upper switch drive |
| a_lo | output | 1 | Leg A lower switch drive |
| b_hi | output | 1 | Leg B upper switch drive |
| b_lo | output | 1 | Leg B lower switch drive |

## Verification
Two functions can meet in the same cycle: clipping of the scaled level and the greater-or-equal tie at the comparator. This happens when an input pair scales past full range while the carrier sits exactly at 255 or 0. The bench applies y=0, d=0 with carrier 255 and expects the upper drive set. It applies y=255, d=0 with carriers 0 and 1 and expects set and then clear. A wrong clip value, or a strict comparison, flips one of these drives. The bench also places the carrier at the exact expected level, and one code above it, across a grid of reference and depth pairs. Near-zero negative products are included, so that rounding toward minus infinity shows up as a one-code error.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  // pipeline stages from input sample to registered scaled level
  localparam int SCALE_LAT = 4;
  // total edges from input sample to drive register
  localparam int OUT_LAT   = SCALE_LAT + 1;
  localparam int LEGS      = 2;
endpackage

// File: rtl/spwm_pipe.sv
module spwm_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else if (g == 0) stage[g] <= din;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/spwm_scale.sv
module spwm_scale #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] idx,
  output logic [DW-1:0] ya
);
  localparam int PW     = 2 * DW;
  localparam int DEN    = (1 << (DW - 1)) - 1;
  localparam int MID    = 1 << (DW - 1);
  localparam int SHIFT  = 2 * DW + 5;
  localparam int RECIP  = (2 ** SHIFT) / DEN;
  localparam int RW     = SHIFT - $clog2(DEN) + 1;
  localparam int QW     = DW + 1;
  localparam int SW     = DW + 2;
  localparam int XW     = PW + RW;

  localparam logic [PW-1:0] DEN_V   = PW'(DEN);
  localparam logic [RW-1:0] RECIP_V = RW'(RECIP);
  localparam logic signed [SW-1:0] MID_S = SW'(MID);
  localparam logic signed [SW-1:0] TOP_S = SW'((1 << DW) - 1);

  // stage 1: remove offset by flipping the sign bit
  logic signed [DW-1:0] c_y, c_i;
  // stage 2: signed product
  logic signed [PW-1:0] prod;
  // stage 3: magnitude and reciprocal estimate
  logic          neg3;
  logic [PW-1:0] mag3;
  logic [QW-1:0] q_est;

  logic [PW-1:0] mag_c;
  logic [XW-1:0] wide;
  logic [PW-1:0] back;
  logic [PW-1:0] rem;
  logic [QW-1:0] q_fix;
  logic signed [SW-1:0] q_sgn;
  logic signed [SW-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_y <= '0;
      c_i <= '0;
    end else begin
      c_y <= signed'({~y[DW-1], y[DW-2:0]});
      c_i <= signed'({~idx[DW-1], idx[DW-2:0]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= c_y * c_i;
  end

  always_comb begin
    mag_c = prod[PW-1] ? PW'(-prod) : PW'(prod);
    wide  = {{RW{1'b0}}, mag_c} * {{PW{1'b0}}, RECIP_V};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg3  <= 1'b0;
      mag3  <= '0;
      q_est <= '0;
    end else begin
      neg3  <= prod[PW-1];
      mag3  <= mag_c;
      q_est <= wide[SHIFT +: QW];
    end
  end

  // stage 4: remainder correction, restore offset, clip
  always_comb begin
    back  = PW'(q_est) * DEN_V;
    rem   = mag3 - back;
    q_fix = q_est + QW'(rem >= DEN_V);
    q_sgn = neg3 ? -signed'(SW'(q_fix)) : signed'(SW'(q_fix));
    sum   = MID_S + q_sgn;
  end

  always_ff @(posedge clk) begin
    if (rst)              ya <= '0;
    else if (sum > TOP_S) ya <= '1;
    else if (sum < 0)     ya <= '0;
    else                  ya <= sum[DW-1:0];
  end
endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] level,
  input  logic [DW-1:0] car,
  output logic          hi,
  output logic          lo
);
  logic on;
  assign on = (level >= car);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= on;
      lo <= ~on;
    end
  end
endmodule

// File: rtl/spwm_bridge.sv
module spwm_bridge
  import spwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ref_a,
  input  logic [DW-1:0] ref_b,
  input  logic [DW-1:0] carrier,
  input  logic [DW-1:0] depth,
  output logic          a_hi,
  output logic          a_lo,
  output logic          b_hi,
  output logic          b_lo
);
  logic [DW-1:0] refs   [LEGS];
  logic [DW-1:0] levels [LEGS];
  logic          his    [LEGS];
  logic          los    [LEGS];
  logic [DW-1:0] car_d;
  logic          vld;

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;

  spwm_pipe #(.W(DW), .DEPTH(SCALE_LAT)) u_car_dly (
    .clk(clk), .rst(rst), .din(carrier), .dout(car_d)
  );

  spwm_pipe #(.W(1), .DEPTH(SCALE_LAT)) u_vld_dly (
    .clk(clk), .rst(rst), .din(1'b1), .dout(vld)
  );

  genvar g;
  generate
    for (g = 0; g < LEGS; g++) begin : g_leg
      spwm_scale #(.DW(DW)) u_scale (
        .clk(clk), .rst(rst), .y(refs[g]), .idx(depth), .ya(levels[g])
      );
      spwm_leg #(.DW(DW)) u_cmp (
        .clk(clk), .rst(rst), .en(vld), .level(levels[g]), .car(car_d),
        .hi(his[g]), .lo(los[g])
      );
    end
  endgenerate

  assign a_hi = his[0];
  assign a_lo = los[0];
  assign b_hi = his[1];
  assign b_lo = los[1];
endmodule

// File: rtl/spwm_bridge_chk.sv
module spwm_bridge_chk
  import spwm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] carrier,
  input logic [DW-1:0] depth,
  input logic          a_hi,
  input logic          a_lo,
  input logic          b_hi,
  input logic          b_lo
);
  localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

  logic [3:0] since_rst;
  logic       full;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < 4'(OUT_LAT)) since_rst <= since_rst + 4'd1;
  end
  assign full = (since_rst == 4'(OUT_LAT));

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> ({a_hi, a_lo, b_hi, b_lo} == 4'b0000)); // R7

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    full |-> ((a_hi != a_lo) && (b_hi != b_lo))); // R4

  AST_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    (full && $past(depth, OUT_LAT) == MID) |->
      ((a_hi == ($past(carrier, OUT_LAT) <= MID)) &&
       (b_hi == ($past(carrier, OUT_LAT) <= MID)))); // R5

  AST_FLOOR_CARRIER: assert property (@(posedge clk) disable iff (rst)
    (full && $past(carrier, OUT_LAT) == '0) |-> (a_hi && b_hi)); // R3
endmodule

bind spwm_bridge spwm_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .carrier(carrier), .depth(depth),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
);

// File: tb/tb_spwm_bridge.sv
module tb_spwm_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ref_a = 8'd128;
  logic [7:0] ref_b = 8'd128;
  logic [7:0] carrier = 8'd0;
  logic [7:0] depth = 8'd128;
  logic       a_hi, a_lo, b_hi, b_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spwm_bridge dut (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b),
    .carrier(carrier), .depth(depth),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
  );

  function automatic int exp_level(int y, int d);
    int p, q;
    p = (y - 128) * (d - 128);
    q = p / 127 + 128;
    if (q > 255) q = 255;
    if (q < 0) q = 0;
    return q;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int ya, input int yb, input int d, input int c);
    @(negedge clk);
    ref_a = 8'(ya); ref_b = 8'(yb); depth = 8'(d); carrier = 8'(c);
  endtask

  // carrier at the exact expected level, then one code above it
  task automatic level_probe(input int y, input int d, input string tag);
    int e;
    e = exp_level(y, d);
    drive(y, y, d, e);
    settle();
    chk({tag, " R3 tie a_hi"}, a_hi, 1'b1);
    chk({tag, " R3 tie b_hi"}, b_hi, 1'b1);
    chk({tag, " R4 a_lo"}, a_lo, 1'b0);
    chk({tag, " R4 b_lo"}, b_lo, 1'b0);
    if (e < 255) begin
      drive(y, y, d, e + 1);
      settle();
      chk({tag, " R3 above a_hi"}, a_hi, 1'b0);
      chk({tag, " R3 above b_hi"}, b_hi, 1'b0);
      chk({tag, " R4 a_lo"}, a_lo, 1'b1);
      chk({tag, " R4 b_lo"}, b_lo, 1'b1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 in reset a_hi", a_hi, 1'b0);
    chk("R7 in reset a_lo", a_lo, 1'b0);
    chk("R7 in reset b_hi", b_hi, 1'b0);
    chk("R7 in reset b_lo", b_lo, 1'b0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 fill a_hi", a_hi, 1'b0);
    chk("R7 fill a_lo", a_lo, 1'b0);
    chk("R7 fill b_lo", b_lo, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 first valid a_hi", a_hi, 1'b1);
    chk("R8 first valid b_hi", b_hi, 1'b1);
  endtask

  task automatic t_latency();
    drive(128, 128, 128, 0);
    settle();
    drive(128, 128, 128, 200);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 carrier before t+4 a_hi", a_hi, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R8 carrier at t+4 a_hi", a_hi, 1'b0);
    drive(255, 255, 255, 200);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 ref before t+4 b_hi", b_hi, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 ref at t+4 b_hi", b_hi, 1'b1);
  endtask

  task automatic t_clip();
    drive(0, 0, 0, 255);
    settle();
    chk("R2 clip high a_hi", a_hi, 1'b1);
    chk("R2 clip high b_hi", b_hi, 1'b1);
    drive(255, 255, 0, 0);
    settle();
    chk("R2 clip low a_hi", a_hi, 1'b1);
    drive(255, 255, 0, 1);
    settle();
    chk("R2 clip low above a_hi", a_hi, 1'b0);
    chk("R2 clip low above b_lo", b_lo, 1'b1);
  endtask

  task automatic t_trunc();
    level_probe(200, 200, "R1 positive");
    level_probe(56, 200, "R1 negative");
    level_probe(0, 129, "R1 small negative");
    level_probe(129, 255, "R1 small positive");
    level_probe(255, 255, "R1 full");
  endtask

  task automatic t_mid();
    for (int y = 0; y < 256; y += 51) begin
      drive(y, 255 - y, 128, 128);
      settle();
      chk("R5 mid tie a_hi", a_hi, 1'b1);
      chk("R5 mid tie b_hi", b_hi, 1'b1);
      drive(y, 255 - y, 128, 129);
      settle();
      chk("R5 mid above a_hi", a_hi, 1'b0);
      chk("R5 mid above b_hi", b_hi, 1'b0);
    end
  endtask

  task automatic t_legs();
    drive(255, 0, 255, 128);
    settle();
    chk("R6 leg A high ref a_hi", a_hi, 1'b1);
    chk("R6 leg B low ref b_hi", b_hi, 1'b0);
    chk("R6 leg B low ref b_lo", b_lo, 1'b1);
    drive(0, 255, 255, 128);
    settle();
    chk("R6 swapped a_hi", a_hi, 1'b0);
    chk("R6 swapped b_hi", b_hi, 1'b1);
  endtask

  task automatic t_grid();
    for (int y = 0; y < 256; y += 17)
      for (int d = 0; d < 256; d += 17)
        level_probe(y, d, "R1 grid");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_clip();
    t_trunc();
    t_mid();
    t_legs();
    t_grid();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual running expected finished");
      report();
    end
  end
endmodule